// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the colour subcarrier for a composite video encoder. A 32-bit accumulator adds a programmable frequency word on every clock. An 8-bit phase offset is added into the top byte of the accumulator. The top ten bits of that sum form a phase index. A folded parabolic approximation of a sine wave is taken from the index for downstream modulation. Alongside the phase, the block keeps a field-sequence counter. It steps on every field-start strobe and wraps after four fields for NTSC or eight fields for PAL.

An external subcarrier-reset pin lets a system realign colour phase with field timing. The pin is synchronised to the clock and only its rising edge counts. The edge arms a pending request and does nothing else at that moment. At the next field-start strobe, the accumulator and the field counter both return to their field-0 values in the same clock.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: On every clock out of reset, with no reset being applied at a field start, the accumulator advances by exactly `freq_word`, modulo 2^32. With `freq_word` = 0x21F07C1F, the phase index therefore follows the running sum of that word.
- R2: `phase_idx` is bits [31:22] of (accumulator + (`phase_ofs` << 24)). It is registered, so it reflects the accumulator value from one clock earlier.
- R3: A rising edge on `sc_reset_pin` passes through a two-flop synchroniser. It arms a pending request on the third rising clock edge after the pin goes high, and the request stays armed until a field start.
- R4: A steady high or low level on `sc_reset_pin` has no effect, and neither has a falling edge. A field start after either one only advances the field counter.
- R5: A field start that finds the request armed clears the accumulator and `field_seq` to 0 at that clock edge, and disarms the request. A rising edge first seen by the arming logic in the same clock as a field start stays armed for the next field start.
- R6: A field start with no request armed increments `field_seq`. The counter wraps from 3 to 0 when `pal_mode` is 0 (NTSC) and from 7 to 0 when `pal_mode` is 1 (PAL). Without a field start, `field_seq` holds.
- R7: While `rst_n` is low at a clock edge, the accumulator, the synchroniser, the pending request, `field_seq`, `phase_idx` and `wave` are all cleared to 0.
- R8: `wave` is a signed value taken from `phase_idx`, one clock later. h = `phase_idx`[8:0] and m = (h*(512-h))>>8. `wave` is m when `phase_idx`[9] is 0 and -m otherwise. For example, index 256 gives 256, 768 gives -256, 128 gives 192 and 640 gives -192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (27 MHz in use) |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | 32 | Phase increment added per clock |
| phase_ofs | input | 8 | Phase offset, added at bit 24 |
| pal_mode | input | 1 | 0 selects the 4-field cycle, 1 the 8-field cycle |
| sc_reset_pin | input | 1 | Asynchronous subcarrier-reset request, rising edge active |
| field_start | input | 1 | One-clock strobe at each field boundary |
| phase_idx | output | 10 | Registered truncated subcarrier phase |
| wave | output | 10 | Signed sine approximation of `phase_idx` |
| field_seq | output | 3 | Field number within the colour sequence |

## Verification
`phase_idx` appears one clock after the accumulator value it is taken from. After a reset release or a reset applied at a field start, the first index sampled is therefore the offset alone, and the first frequency step shows one clock later. `wave` lags `phase_idx` by one more clock. `field_seq` changes at the same edge that samples `field_start`. A pin edge needs three edges before a field start can act on it. The bench drives inputs on falling edges and counts whole clocks before each sample. It also samples deliberately one clock early in a few places, to confirm that a result has not yet arrived.

// File: rtl/scr_pkg.sv
// Package: shared constants and types for the subcarrier phase generator.
// Assumes: field-cycle lengths are powers of two no larger than 2**SEQ_W.
package scr_pkg;

    // Colour-sequence length selected by the standard input
    localparam int NTSC_FIELD_CYCLE = 4;
    localparam int PAL_FIELD_CYCLE  = 8;

    // Standard selector as carried on the pal_mode pin
    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } video_std_e;

endpackage

// File: rtl/scr_reset_capture.sv
// Module: synchronises the subcarrier-reset pin, detects its rising edge and
// keeps a pending request until the next field start.
// Assumes: field_start is a single-clock strobe in the clk domain.
module scr_reset_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic field_start,
    output logic edge_seen,
    output logic pending,
    output logic apply_now
);

    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain_q;

    generate
        for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first synchroniser flop samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_async;
                end
            end else begin : g_next
                // Purpose: later flops extend the chain; the last one is the edge history
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // Purpose: rising edge of the synchronised level
    assign edge_seen = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // Purpose: a request acts only when already armed at a field start
    assign apply_now = field_start & pending;

    // Purpose: arm on an edge; a field start consumes the armed request
    always_ff @(posedge clk) begin
        if (!rst_n)           pending <= 1'b0;
        else if (field_start) pending <= edge_seen;
        else if (edge_seen)   pending <= 1'b1;
    end

endmodule

// File: rtl/scr_phase_accum.sv
// Module: direct digital synthesis accumulator and registered phase index.
// Assumes: PHASE_W > OFS_W and the offset occupies the top OFS_W bits.
module scr_phase_accum #(
    parameter int ACC_W   = 32,
    parameter int OFS_W   = 8,
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   freq_word,
    input  logic [OFS_W-1:0]   phase_ofs,
    input  logic               clear,
    output logic [ACC_W-1:0]   acc,
    output logic [PHASE_W-1:0] phase_idx
);

    localparam int OFS_LSB = ACC_W - OFS_W;
    localparam int LOW_W   = PHASE_W - OFS_W;

    logic [OFS_W-1:0]   top_sum;
    logic [PHASE_W-1:0] idx_next;

    // Purpose: offset only touches the top byte, so no carry enters from below
    always_comb begin
        top_sum  = acc[ACC_W-1:OFS_LSB] + phase_ofs;
        idx_next = {top_sum, acc[OFS_LSB-1 -: LOW_W]};
    end

    // Purpose: advance the phase or return it to field 0
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else            acc <= acc + freq_word;
    end

    // Purpose: register the truncated phase
    always_ff @(posedge clk) begin
        if (!rst_n) phase_idx <= '0;
        else        phase_idx <= idx_next;
    end

endmodule

// File: rtl/scr_field_seq.sv
// Module: field-sequence counter with a per-standard wrap point.
// Assumes: clear and field_start may coincide; clear wins.
module scr_field_seq #(
    parameter int SEQ_W     = 3,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_cycle,
    input  logic             field_start,
    input  logic             clear,
    output logic [SEQ_W-1:0] field_seq
);

    localparam logic [SEQ_W-1:0] SHORT_LAST = SEQ_W'(SHORT_LEN - 1);
    localparam logic [SEQ_W-1:0] LONG_LAST  = SEQ_W'(LONG_LEN - 1);

    logic [SEQ_W-1:0] last_val;

    // Purpose: choose the final field number of the active cycle
    always_comb begin
        last_val = long_cycle ? LONG_LAST : SHORT_LAST;
    end

    // Purpose: step, wrap or clear the field number
    always_ff @(posedge clk) begin
        if (!rst_n)                       field_seq <= '0;
        else if (clear)                   field_seq <= '0;
        else if (field_start) begin
            if (field_seq >= last_val)    field_seq <= '0;
            else                          field_seq <= field_seq + 1'b1;
        end
    end

endmodule

// File: rtl/scr_wave_fold.sv
// Module: signed sine approximation from the phase index; each half period
// is a parabola folded about the midpoint. Registered, one clock latency.
// Assumes: PHASE_W >= 3.
module scr_wave_fold #(
    parameter int PHASE_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PHASE_W-1:0]        phase_idx,
    output logic signed [PHASE_W-1:0] wave
);

    localparam int HALF_W = PHASE_W - 1;
    localparam int PROD_W = 2 * HALF_W + 1;
    localparam logic [HALF_W:0] HALF_SPAN = (HALF_W+1)'(1) << HALF_W;

    logic [HALF_W:0]          pos;
    logic [HALF_W:0]          rem;
    logic [PROD_W-1:0]        prod;
    logic [PROD_W-1:0]        scaled;
    logic signed [PHASE_W-1:0] mag;
    logic signed [PHASE_W-1:0] wave_next;

    // Purpose: parabola h*(span-h) scaled back to HALF_W-1 bits of magnitude
    always_comb begin
        pos       = {1'b0, phase_idx[HALF_W-1:0]};
        rem       = HALF_SPAN - pos;
        prod      = PROD_W'(pos) * PROD_W'(rem);
        scaled    = prod >> (HALF_W - 1);
        mag       = signed'(scaled[PHASE_W-1:0]);
        wave_next = phase_idx[PHASE_W-1] ? -mag : mag;
    end

    // Purpose: register the wave sample
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= '0;
        else        wave <= wave_next;
    end

endmodule

// File: rtl/subcarrier_phase_gen.sv
// Module: top of the subcarrier phase generator. Ties the reset capture,
// accumulator, field counter and wave approximation together.
// Assumes: one clock domain; field_start one clock wide.
module subcarrier_phase_gen #(
    parameter int ACC_W       = 32,
    parameter int OFS_W       = 8,
    parameter int PHASE_W     = 10,
    parameter int SEQ_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ACC_W-1:0]          freq_word,
    input  logic [OFS_W-1:0]          phase_ofs,
    input  logic                      pal_mode,
    input  logic                      sc_reset_pin,
    input  logic                      field_start,
    output logic [PHASE_W-1:0]        phase_idx,
    output logic signed [PHASE_W-1:0] wave,
    output logic [SEQ_W-1:0]          field_seq
);

    import scr_pkg::*;

    logic             edge_seen;
    logic             pending;
    logic             apply_now;
    logic [ACC_W-1:0] acc_q;
    video_std_e       std_sel;

    // Purpose: name the standard selection
    assign std_sel = video_std_e'(pal_mode);

    scr_reset_capture #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async   (sc_reset_pin),
        .field_start (field_start),
        .edge_seen   (edge_seen),
        .pending     (pending),
        .apply_now   (apply_now)
    );

    scr_phase_accum #(
        .ACC_W   (ACC_W),
        .OFS_W   (OFS_W),
        .PHASE_W (PHASE_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .phase_ofs (phase_ofs),
        .clear     (apply_now),
        .acc       (acc_q),
        .phase_idx (phase_idx)
    );

    scr_field_seq #(
        .SEQ_W     (SEQ_W),
        .SHORT_LEN (NTSC_FIELD_CYCLE),
        .LONG_LEN  (PAL_FIELD_CYCLE)
    ) u_fseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_cycle  (std_sel == STD_PAL),
        .field_start (field_start),
        .clear       (apply_now),
        .field_seq   (field_seq)
    );

    scr_wave_fold #(
        .PHASE_W (PHASE_W)
    ) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_idx (phase_idx),
        .wave      (wave)
    );

endmodule

// File: rtl/scr_checker.sv
// Module: temporal checks on the subcarrier phase generator, bound to the top.
// Assumes: default parameter layout (offset at the top byte of the accumulator).
module scr_checker #(
    parameter int ACC_W   = 32,
    parameter int OFS_W   = 8,
    parameter int PHASE_W = 10,
    parameter int SEQ_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ACC_W-1:0]          freq_word,
    input logic [OFS_W-1:0]          phase_ofs,
    input logic                      pal_mode,
    input logic                      field_start,
    input logic                      edge_seen,
    input logic                      pending,
    input logic [ACC_W-1:0]          acc,
    input logic [PHASE_W-1:0]        phase_idx,
    input logic signed [PHASE_W-1:0] wave,
    input logic [SEQ_W-1:0]          field_seq
);

    logic [ACC_W-1:0] ofs_wide;
    logic [ACC_W-1:0] chk_sum;
    assign ofs_wide = ACC_W'(phase_ofs) << (ACC_W - OFS_W);
    assign chk_sum  = acc + ofs_wide;

    assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(field_start && pending) |=> acc == $past(acc) + $past(freq_word));

    assert_phase_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_idx == $past(chk_sum[ACC_W-1 -: PHASE_W]));

    assert_arm_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(edge_seen));

    assert_hold_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !field_start) |=> pending);

    assert_field_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && pending) |=> (field_seq == '0 && acc == '0));

    assert_ntsc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !pal_mode) |=> field_seq < SEQ_W'(4));

    assert_seq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(field_seq));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && field_seq == '0 && !pending && phase_idx == '0));

    assert_wave_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_idx[PHASE_W-1] |=> !wave[PHASE_W-1]);

endmodule

bind subcarrier_phase_gen scr_checker #(
    .ACC_W   (ACC_W),
    .OFS_W   (OFS_W),
    .PHASE_W (PHASE_W),
    .SEQ_W   (SEQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .freq_word   (freq_word),
    .phase_ofs   (phase_ofs),
    .pal_mode    (pal_mode),
    .field_start (field_start),
    .edge_seen   (edge_seen),
    .pending     (pending),
    .acc         (acc_q),
    .phase_idx   (phase_idx),
    .wave        (wave),
    .field_seq   (field_seq)
);

// File: tb/subcarrier_phase_gen_tb.sv
// Bench: vector table for phase arithmetic, then directed field/reset tests.
module subcarrier_phase_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] freq_word = '0;
    logic [7:0]  phase_ofs = '0;
    logic        pal_mode = 1'b0;
    logic        sc_reset_pin = 1'b0;
    logic        field_start = 1'b0;
    logic [9:0]  phase_idx;
    logic signed [9:0] wave;
    logic [2:0]  field_seq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    subcarrier_phase_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_word    (freq_word),
        .phase_ofs    (phase_ofs),
        .pal_mode     (pal_mode),
        .sc_reset_pin (sc_reset_pin),
        .field_start  (field_start),
        .phase_idx    (phase_idx),
        .wave         (wave),
        .field_seq    (field_seq)
    );

    // {freq_word, phase_ofs, clocks after release, expected phase_idx}
    localparam int NVEC = 5;
    localparam logic [57:0] VEC [NVEC] = '{
        {32'h0040_0000, 8'h00, 8'd5, 10'd4},
        {32'h0040_0000, 8'h01, 8'd5, 10'd8},
        {32'hFFC0_0000, 8'h00, 8'd3, 10'd1022},
        {32'h21F0_7C1F, 8'h00, 8'd2, 10'd135},
        {32'h0000_0000, 8'h80, 8'd4, 10'd512}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_field();
        field_start = 1'b1;
        tick(1);
        field_start = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] model;
        tick(1);
        // R7: reset state
        check(phase_idx == 0 && wave == 0 && field_seq == 0, "R7 reset outputs",
              int'(phase_idx), 0);

        // R2: vector table
        for (int v = 0; v < NVEC; v++) begin
            freq_word = VEC[v][57:26];
            phase_ofs = VEC[v][25:18];
            do_reset();
            tick(int'(VEC[v][17:10]));
            check(phase_idx == VEC[v][9:0], "R2 vector phase", int'(phase_idx),
                  int'(VEC[v][9:0]));
        end

        // R1: NTSC word advances exactly once per clock
        freq_word = 32'h21F0_7C1F;
        phase_ofs = 8'h00;
        do_reset();
        model = '0;
        for (int n = 0; n < 2000; n++) begin
            tick(1);
            check(phase_idx == model[31:22], "R1 accumulator step", int'(phase_idx),
                  int'(model[31:22]));
            model = model + 32'h21F0_7C1F;
        end

        // R8: wave values and latency (freq 0, constant phase)
        freq_word = '0;
        phase_ofs = 8'h40;
        do_reset();
        tick(3);
        check(wave == 256, "R8 wave at 256", int'(wave), 256);
        phase_ofs = 8'hC0;
        tick(1);
        check(wave == 256, "R8 wave not yet updated", int'(wave), 256);
        tick(1);
        check(wave == -256, "R8 wave at 768", int'(wave), -256);
        phase_ofs = 8'h20;
        tick(2);
        check(wave == 192, "R8 wave at 128", int'(wave), 192);
        phase_ofs = 8'hA0;
        tick(2);
        check(wave == -192, "R8 wave at 640", int'(wave), -192);

        // R6: NTSC wrap
        freq_word = 32'h0040_0000;
        phase_ofs = 8'h00;
        pal_mode = 1'b0;
        do_reset();
        tick(1);
        check(field_seq == 0, "R6 hold without strobe", int'(field_seq), 0);
        for (int k = 1; k <= 5; k++) begin
            pulse_field();
            check(field_seq == 3'(k % 4), "R6 ntsc sequence", int'(field_seq), k % 4);
        end
        // R6: PAL wrap
        pal_mode = 1'b1;
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            pulse_field();
            check(field_seq == 3'(k % 8), "R6 pal sequence", int'(field_seq), k % 8);
        end
        pal_mode = 1'b0;

        // R3/R5: armed request applies at next field start
        do_reset();
        pulse_field();
        pulse_field();
        sc_reset_pin = 1'b1;
        tick(3);
        pulse_field();
        check(field_seq == 0, "R5 field reset", int'(field_seq), 0);
        tick(1);
        check(phase_idx == 0, "R5 phase from zero", int'(phase_idx), 0);
        tick(1);
        check(phase_idx == 1, "R5 phase first step", int'(phase_idx), 1);

        // R4: steady high level and falling edge do nothing
        tick(5);
        pulse_field();
        check(field_seq == 1, "R4 level ignored", int'(field_seq), 1);
        sc_reset_pin = 1'b0;
        tick(5);
        pulse_field();
        check(field_seq == 2, "R4 falling edge ignored", int'(field_seq), 2);

        // R3: pin edge too recent does not act; coincident edge stays armed (R5)
        tick(4);
        sc_reset_pin = 1'b1;
        tick(2);
        pulse_field();
        check(field_seq == 3, "R3 coincident edge not applied", int'(field_seq), 3);
        tick(3);
        pulse_field();
        check(field_seq == 0, "R5 coincident edge applied next", int'(field_seq), 0);

        // R7: reset clears an armed request and running state
        sc_reset_pin = 1'b0;
        tick(4);
        sc_reset_pin = 1'b1;
        tick(3);
        pulse_field();
        pulse_field();
        sc_reset_pin = 1'b0;
        tick(4);
        sc_reset_pin = 1'b1;
        tick(3);
        sc_reset_pin = 1'b0;
        rst_n = 1'b0;
        tick(1);
        check(field_seq == 0 && phase_idx == 0, "R7 mid-run reset", int'(phase_idx), 0);
        tick(1);
        rst_n = 1'b1;
        tick(2);
        pulse_field();
        check(field_seq == 1, "R7 pending cleared by reset", int'(field_seq), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule